// File: doc/BRIEF.md
# PLL and Peripheral Clock Rate Calculator

This block models the frequency plan of a small clock tree without producing any toggling clocks. It stores three PLL control words and one peripheral clock control word. It takes the period of the reference clock as an integer and computes the output periods of two peripheral reference clocks. Each of those clocks is derived from one of the three PLLs. Downstream models read those periods to scale their own timing.

A write to any control word starts a recompute. So does any change of the effective reference period, and that includes entering or leaving the hold-in-reset state. The three PLL periods are produced by iterative restoring dividers that run in parallel. A source mux and a divisor multiply then form each peripheral period. Both results are registered together, and a one-cycle done strobe marks the cycle in which they take their new values. If a trigger arrives while a computation is running, the block runs one more computation afterwards, so the final result always reflects the latest inputs.

Top module: `clk_rate_calc`

## Requirements
- R1: On `rst_n` low, both period outputs and `done` are 0. Each PLL word resets to 0x0001A008, which gives multiplier 26. The peripheral word resets to 0x00003F03: source 0, divisor 63, both enables set. After release, with reference period P, both outputs settle to (P/26)*63.
- R2: When PLL control bit 4 (bypass) is set, that PLL's period equals the reference period, whatever bits 0 and 1 hold.
- R3: When bypass is clear and PLL bit 0 (reset) or bit 1 (power-down) is set, that PLL's period is 0.
- R4: In any other case the PLL period is the reference period divided by the multiplier in bits 18:12, truncated. A multiplier of 0 gives 0.
- R5: `wr_addr` 0, 1 and 2 select PLL words A, B and C, and 3 selects the peripheral word. Peripheral bits 5:4 pick the source: values 0 and 1 pick PLL A, 2 picks PLL B and 3 picks PLL C.
- R6: Peripheral bits 13:8 hold a divisor that multiplies the source period. A divisor of 0 acts as 1.
- R7: Peripheral bit 0 enables output 0 and bit 1 enables output 1. A cleared enable makes that output 0.
- R8: While `hold_rst` is high the reference period is taken as 0, so both outputs become 0. After release the outputs are recomputed from the stored, unchanged control words.
- R9: A control write or a change of the reference period starts a recompute. A trigger that arrives during a computation causes one more, so the settled outputs reflect the last inputs.
- R10: `done` is high for one cycle at a time. The outputs change only in a cycle where `done` is high, and in that cycle they already show the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_rst | input | 1 | Hold-in-reset flag; forces the effective reference period to 0 |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | 2 | Control word select (0..2 PLL A..C, 3 peripheral) |
| wr_data | input | 32 | Control word write data |
| ref_period | input | 32 | Reference clock period |
| per0_period | output | 38 | Period of peripheral clock 0 (0 = off) |
| per1_period | output | 38 | Period of peripheral clock 1 (0 = off) |
| done | output | 1 | One-cycle strobe: new periods presented |

## Verification
The bench checks the priority order in the PLL words: bypass together with reset or power-down, and reset without bypass. A design that tested reset before bypass would report 0 where the reference period is expected. It aims at a zero multiplier and a zero divisor, which a careless design would turn into an all-ones quotient or a zero output. It checks that source codes 0 and 1 alias to the same PLL, and it uses the largest reference period so that a truncating multiply would show up. It also rewrites a word in the middle of a computation and checks hold-in-reset. A design that dropped the late trigger would settle on stale values. A design that cleared the stored words on hold would not return to the earlier periods.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;

    // PLL control word fields
    localparam int PLL_RST_BIT  = 0;
    localparam int PLL_PD_BIT   = 1;
    localparam int PLL_BYP_BIT  = 4;
    localparam int PLL_MULT_LSB = 12;

    // peripheral control word fields
    localparam int PER_EN_LSB   = 0;
    localparam int PER_SRC_LSB  = 4;
    localparam int PER_DIV_LSB  = 8;

    localparam logic [31:0] PLL_CTRL_INIT = 32'h0001_A008;
    localparam logic [31:0] PER_CTRL_INIT = 32'h0000_3F03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN
    } calc_state_e;

    // source code to PLL index: 0,1 -> A, 2 -> B, 3 -> C
    function automatic logic [1:0] src_to_pll(input logic [1:0] src);
        return (src == 2'd0) ? 2'd0 : (src - 2'd1);
    endfunction

endpackage

// File: rtl/clk_rate_div.sv
module clk_rate_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             valid
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] dvd;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
    } div_st_t;

    div_st_t q, d;

    logic [DEN_W:0] rem_s;
    logic [DEN_W:0] den_x;
    logic           qbit;

    always_comb begin
        d     = q;
        d.valid = 1'b0;
        rem_s = {q.rem, q.dvd[NUM_W-1]};
        den_x = {1'b0, den};
        qbit  = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(NUM_W);
            d.dvd  = num;
            d.quo  = '0;
            d.rem  = '0;
        end else if (q.busy) begin
            d.dvd = q.dvd << 1;
            if (rem_s >= den_x) begin
                qbit  = 1'b1;
                d.rem = DEN_W'(rem_s - den_x);
            end else begin
                d.rem = rem_s[DEN_W-1:0];
            end
            d.quo = {q.quo[NUM_W-2:0], qbit};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy  = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quo   = q.quo;
    assign valid = q.valid;

endmodule

// File: rtl/clk_rate_pll.sv
module clk_rate_pll
    import clk_rate_pkg::*;
#(
    parameter int PERIOD_W = 32,
    parameter int MULT_W   = 7,
    parameter int CTRL_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CTRL_W-1:0]   ctrl,
    input  logic [PERIOD_W-1:0] period,
    output logic [PERIOD_W-1:0] per,
    output logic                valid
);
    logic [MULT_W-1:0]   mult;
    logic [PERIOD_W-1:0] quo;
    logic                unused_ctrl;

    assign mult = ctrl[PLL_MULT_LSB +: MULT_W];
    assign unused_ctrl = ^{ctrl[CTRL_W-1:PLL_MULT_LSB+MULT_W],
                           ctrl[PLL_MULT_LSB-1:PLL_BYP_BIT+1],
                           ctrl[PLL_BYP_BIT-1:PLL_PD_BIT+1]};

    clk_rate_div #(
        .NUM_W(PERIOD_W),
        .DEN_W(MULT_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .num  (period),
        .den  (mult),
        .quo  (quo),
        .valid(valid)
    );

    // priority: bypass, then reset / power-down, then zero multiplier
    always_comb begin
        if (ctrl[PLL_BYP_BIT])
            per = period;
        else if (ctrl[PLL_RST_BIT] || ctrl[PLL_PD_BIT])
            per = '0;
        else if (mult == '0)
            per = '0;
        else
            per = quo;
    end

endmodule

// File: rtl/clk_rate_per_sel.sv
module clk_rate_per_sel
    import clk_rate_pkg::*;
#(
    parameter int PERIOD_W = 32,
    parameter int DIV_W    = 6,
    parameter int CTRL_W   = 32,
    parameter int NUM_PLL  = 3,
    parameter int NUM_OUT  = 2,
    localparam int OUT_W   = PERIOD_W + DIV_W
) (
    input  logic [NUM_PLL-1:0][PERIOD_W-1:0] pll_per,
    input  logic [CTRL_W-1:0]                ctrl,
    output logic [NUM_OUT-1:0][OUT_W-1:0]    per
);
    logic [1:0]          src;
    logic [DIV_W-1:0]    div_raw;
    logic [DIV_W-1:0]    div_eff;
    logic [PERIOD_W-1:0] src_per;
    logic [OUT_W-1:0]    scaled;
    logic                unused_ctrl;

    assign src     = ctrl[PER_SRC_LSB +: 2];
    assign div_raw = ctrl[PER_DIV_LSB +: DIV_W];
    assign div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
    assign src_per = pll_per[src_to_pll(src)];
    assign scaled  = OUT_W'(src_per) * OUT_W'(div_eff);
    assign unused_ctrl = ^{ctrl[CTRL_W-1:PER_DIV_LSB+DIV_W],
                           ctrl[PER_DIV_LSB-1:PER_SRC_LSB+2],
                           ctrl[PER_SRC_LSB-1:PER_EN_LSB+NUM_OUT]};

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign per[g] = ctrl[PER_EN_LSB + g] ? scaled : '0;
    end

endmodule

// File: rtl/clk_rate_calc.sv
module clk_rate_calc
    import clk_rate_pkg::*;
#(
    parameter int PERIOD_W = 32,
    parameter int MULT_W   = 7,
    parameter int DIV_W    = 6,
    parameter int CTRL_W   = 32,
    localparam int NUM_PLL = 3,
    localparam int NUM_OUT = 2,
    localparam int ADDR_W  = $clog2(NUM_PLL + 1),
    localparam int OUT_W   = PERIOD_W + DIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CTRL_W-1:0]   wr_data,
    input  logic [PERIOD_W-1:0] ref_period,
    output logic [OUT_W-1:0]    per0_period,
    output logic [OUT_W-1:0]    per1_period,
    output logic                done
);
    localparam logic [ADDR_W-1:0] PER_ADDR = ADDR_W'(NUM_PLL);

    typedef struct packed {
        calc_state_e                       state;
        logic                              pending;
        logic [NUM_PLL-1:0][CTRL_W-1:0]    pll_ctrl;
        logic [CTRL_W-1:0]                 per_ctrl;
        logic [PERIOD_W-1:0]               eff;
        logic [NUM_PLL-1:0][CTRL_W-1:0]    snap_pll;
        logic [CTRL_W-1:0]                 snap_per;
        logic [PERIOD_W-1:0]               snap_eff;
        logic [NUM_OUT-1:0][OUT_W-1:0]     out;
        logic                              done;
    } calc_st_t;

    calc_st_t q, d;

    logic [PERIOD_W-1:0]              eff_now;
    logic                             trig;
    logic                             start_w;
    logic [NUM_PLL-1:0][PERIOD_W-1:0] pll_per;
    logic [NUM_PLL-1:0]               pll_valid;
    logic [NUM_OUT-1:0][OUT_W-1:0]    per_new;

    // views for the bound checker
    logic [CTRL_W-1:0]   snap_per_w;
    logic [PERIOD_W-1:0] snap_eff_w;
    logic                snap_byp_a_w;
    assign snap_per_w   = q.snap_per;
    assign snap_eff_w   = q.snap_eff;
    assign snap_byp_a_w = q.snap_pll[0][PLL_BYP_BIT];

    assign eff_now = hold_rst ? '0 : ref_period;
    assign trig    = wr_en || (eff_now != q.eff);
    assign start_w = (q.state == ST_LOAD);

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        clk_rate_pll #(
            .PERIOD_W(PERIOD_W),
            .MULT_W  (MULT_W),
            .CTRL_W  (CTRL_W)
        ) u_pll (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start_w),
            .ctrl  (q.snap_pll[p]),
            .period(q.snap_eff),
            .per   (pll_per[p]),
            .valid (pll_valid[p])
        );
    end

    clk_rate_per_sel #(
        .PERIOD_W(PERIOD_W),
        .DIV_W   (DIV_W),
        .CTRL_W  (CTRL_W),
        .NUM_PLL (NUM_PLL),
        .NUM_OUT (NUM_OUT)
    ) u_sel (
        .pll_per(pll_per),
        .ctrl   (q.snap_per),
        .per    (per_new)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.eff  = eff_now;
        if (wr_en) begin
            if (wr_addr == PER_ADDR)
                d.per_ctrl = wr_data;
            else if (wr_addr < PER_ADDR)
                d.pll_ctrl[wr_addr] = wr_data;
        end
        case (q.state)
            ST_IDLE: begin
                if (q.pending || trig) begin
                    d.snap_pll = d.pll_ctrl;
                    d.snap_per = d.per_ctrl;
                    d.snap_eff = eff_now;
                    d.pending  = 1'b0;
                    d.state    = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (trig) d.pending = 1'b1;
                d.state = ST_RUN;
            end
            ST_RUN: begin
                if (trig) d.pending = 1'b1;
                if (&pll_valid) begin
                    d.out   = per_new;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.pending  <= 1'b1;
            q.pll_ctrl <= {NUM_PLL{CTRL_W'(PLL_CTRL_INIT)}};
            q.per_ctrl <= CTRL_W'(PER_CTRL_INIT);
        end else begin
            q <= d;
        end
    end

    assign per0_period = q.out[0];
    assign per1_period = q.out[1];
    assign done        = q.done;

endmodule

// File: rtl/clk_rate_calc_chk.sv
module clk_rate_calc_chk
    import clk_rate_pkg::*;
#(
    parameter int PERIOD_W = 32,
    parameter int DIV_W    = 6,
    localparam int OUT_W   = PERIOD_W + DIV_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done,
    input logic [OUT_W-1:0]    per0_period,
    input logic [OUT_W-1:0]    per1_period,
    input logic [1:0]          snap_en,
    input logic [1:0]          snap_src,
    input logic [DIV_W-1:0]    snap_div,
    input logic [PERIOD_W-1:0] snap_eff,
    input logic                snap_byp_a,
    input logic [PERIOD_W-1:0] pll_a_per,
    input logic [PERIOD_W-1:0] pll_b_per,
    input logic                pll_a_valid
);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(per0_period) && $stable(per1_period)));

    // R7
    en0_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !snap_en[0]) |-> (per0_period == '0));

    // R7
    en1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !snap_en[1]) |-> (per1_period == '0));

    // R8
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && snap_eff == '0) |-> (per0_period == '0 && per1_period == '0));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_a_valid && snap_byp_a) |-> (pll_a_per == snap_eff));

    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && snap_en[0] && snap_div == '0 && snap_src == 2'd2)
        |-> (per0_period == OUT_W'(pll_b_per)));

endmodule

bind clk_rate_calc clk_rate_calc_chk #(
    .PERIOD_W(PERIOD_W),
    .DIV_W   (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .per0_period(per0_period),
    .per1_period(per1_period),
    .snap_en    (snap_per_w[1:0]),
    .snap_src   (snap_per_w[5:4]),
    .snap_div   (snap_per_w[8 +: DIV_W]),
    .snap_eff   (snap_eff_w),
    .snap_byp_a (snap_byp_a_w),
    .pll_a_per  (pll_per[0]),
    .pll_b_per  (pll_per[1]),
    .pll_a_valid(pll_valid[0])
);

// File: tb/sim_clk_rate_calc.sv
module sim_clk_rate_calc;

    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ref_period = 32'd2600;
    logic [37:0] per0_period, per1_period;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    clk_rate_calc u0 (
        .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_period(ref_period),
        .per0_period(per0_period), .per1_period(per1_period), .done(done)
    );

    always @(negedge clk) if (done) done_cnt++;

    // stimulus and expected vectors: ref, PLL A/B/C words, peripheral word, out0, out1
    localparam logic [31:0] V_REF [NV] = '{32'd2600, 32'd1000, 32'd1000, 32'd1000,
        32'd1000, 32'd1000, 32'd1000, 32'd1003, 32'hFFFF_FFFF, 32'd127000, 32'd500, 32'd777};
    localparam logic [31:0] V_PA [NV] = '{32'h1A008, 32'hA000, 32'hA000, 32'hA011,
        32'hA000, 32'hA000, 32'h0, 32'h7000, 32'h1A018, 32'h1A008, 32'h1A008, 32'h1000};
    localparam logic [31:0] V_PB [NV] = '{32'h1A008, 32'h4000, 32'h4000, 32'h4000,
        32'h4001, 32'h4000, 32'h4000, 32'h4000, 32'h4000, 32'h1A008, 32'h3012, 32'h4000};
    localparam logic [31:0] V_PC [NV] = '{32'h1A008, 32'h8000, 32'h8000, 32'h8000,
        32'h8000, 32'h8002, 32'h8000, 32'h8000, 32'h8000, 32'h7F000, 32'h8000, 32'h8000};
    localparam logic [31:0] V_PH [NV] = '{32'h3F03, 32'h0321, 32'h0032, 32'h0213,
        32'h0523, 32'h0133, 32'h0703, 32'h3F03, 32'h3F03, 32'h0A31, 32'h0423, 32'h0113};
    localparam logic [63:0] V_E0 [NV] = '{64'd6300, 64'd750, 64'd0, 64'd2000,
        64'd0, 64'd0, 64'd0, 64'd9009, 64'd270582939585, 64'd10000, 64'd2000, 64'd777};
    localparam logic [63:0] V_E1 [NV] = '{64'd6300, 64'd0, 64'd125, 64'd2000,
        64'd0, 64'd0, 64'd0, 64'd9009, 64'd270582939585, 64'd0, 64'd2000, 64'd777};
    localparam string V_TAG [NV] = '{"R5 R6 src0", "R4 R5 R7 src2 en0", "R6 R7 div0 src3 en1",
        "R2 bypass over reset", "R3 reset bit", "R3 powerdown bit", "R4 mult zero",
        "R4 truncating divide", "R2 R6 max period", "R4 R5 mult127 src3", "R2 bypass over powerdown",
        "R5 src1 aliases A"};

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (120) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [37:0] old0;
        bit          changed_early;
        bit          seen;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 out0 in reset", 64'(per0_period), 64'd0);
        check("R1 out1 in reset", 64'(per1_period), 64'd0);
        check("R1 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        settle();
        check("R1 default words out0", 64'(per0_period), 64'd6300);
        check("R1 default words out1", 64'(per1_period), 64'd6300);

        // table walk
        for (int i = 0; i < NV; i++) begin
            ref_period = V_REF[i];
            wr(2'd0, V_PA[i]);
            wr(2'd1, V_PB[i]);
            wr(2'd2, V_PC[i]);
            wr(2'd3, V_PH[i]);
            settle();
            check({V_TAG[i], " out0"}, 64'(per0_period), V_E0[i]);
            check({V_TAG[i], " out1"}, 64'(per1_period), V_E1[i]);
        end

        // R10: single compute, outputs change exactly with done
        done_cnt = 0;
        old0 = per0_period;
        changed_early = 1'b0;
        seen = 1'b0;
        wr(2'd3, 32'h0213);
        for (int k = 0; k < 100 && !seen; k++) begin
            if (done) begin
                seen = 1'b1;
                check("R10 out0 at done", 64'(per0_period), 64'd1554);
                check("R10 out1 at done", 64'(per1_period), 64'd1554);
            end else begin
                if (per0_period != old0) changed_early = 1'b1;
                @(negedge clk);
            end
        end
        check("R10 done seen", 64'(seen), 64'd1);
        check("R10 no change before done", 64'(changed_early), 64'd0);
        settle();
        check("R10 one done per compute", 64'(done_cnt), 64'd1);

        // R9: rewrite in the middle of a compute
        done_cnt = 0;
        wr(2'd3, 32'h0313);
        repeat (10) @(negedge clk);
        wr(2'd3, 32'h0413);
        settle();
        check("R9 late write wins out0", 64'(per0_period), 64'd3108);
        check("R9 late write wins out1", 64'(per1_period), 64'd3108);
        check("R9 second compute ran", 64'(done_cnt), 64'd2);

        // R9: period change alone triggers
        ref_period = 32'd1000;
        settle();
        check("R9 period change out0", 64'(per0_period), 64'd4000);

        // R8: hold flag
        @(negedge clk);
        hold_rst = 1'b1;
        settle();
        check("R8 hold out0", 64'(per0_period), 64'd0);
        check("R8 hold out1", 64'(per1_period), 64'd0);
        hold_rst = 1'b0;
        settle();
        check("R8 release out0", 64'(per0_period), 64'd4000);
        check("R8 release out1", 64'(per1_period), 64'd4000);

        finish_run();
    end

endmodule